// File: doc/BRIEF.md
# Sa-bit error report counter

This block sits behind an E1 receive framer that already delivers frame-aligned data in CRC-4 multiframe mode. The far end can report errors it has seen by sending a short code on one of the spare Sa bits. The block takes one bit from the chosen Sa position in each of the four non-alignment frames of a submultiframe and builds a 4-bit word from them. It compares that word with two reference patterns, either the built-in pair or a pair set by the user, and counts each submultiframe whose word matches.

Frames arrive on a valid/ready stream, one beat per frame. The block accepts one beat on every cycle and never applies back-pressure. `frm_ready` is low only while reset is asserted, and a beat with `frm_valid` low carries nothing. Counting happens only while the multiframe lock input stays high. A single-cycle latch pulse moves the running count into a readable holding register and clears the running count.

Top module: `sa_err_report_cnt`

## Requirements
- R1: While `rst_n` is low, `hold_cnt` is 0 and `frm_ready` is 0. The running count also resets to 0.
- R2: `frm_ready` is 1 on every cycle after the first clock edge with `rst_n` high. A frame is taken only on a cycle where `frm_valid` and `frm_ready` are both 1. A cycle with `frm_valid` low has no effect, whatever data it carries.
- R3: `cfg_sa_sel` chooses the watched bit of `frm_sa`. Bit 0 of `frm_sa` is Sa4 and bit 4 is Sa8, and value n selects bit n. The values 5 to 7 select Sa8.
- R4: `frm_index` counts 0 to 15 across the multiframe. Indices 0–7 form the first submultiframe and 8–15 the second. The frames at odd indices (1, 3, 5, 7 and 9, 11, 13, 15) each give one bit of the word, with the earliest bit as the MSB. The word is evaluated on the frame at index 7 or 15. Every frame used must belong to the same submultiframe as the frame at index 0 or 8 that started the collection.
- R5: When `cfg_user_pat` is 0, a word equal to 4'b0010 or 4'b0011 is a match.
- R6: When `cfg_user_pat` is 1, a word equal to `cfg_pat_a` or `cfg_pat_b` is a match, and the built-in patterns do not match.
- R7: Collection starts on a frame at index 0 or 8 that is taken while `mf_lock` is 1. If `mf_lock` is 0 on any cycle, the partial word is dropped. A submultiframe counts only if a fresh collection has started at its first frame.
- R8: Each matching submultiframe adds exactly one to the running count, on the second clock edge after its last frame is taken.
- R9: The running count stops at all ones and does not wrap.
- R10: On a clock edge where `latch` is 1, `hold_cnt` takes the running count and the running count becomes 0. If an increment falls on that same edge, the running count becomes 1.
- R11: The running count and `hold_cnt` are 16 bits wide by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A frame beat is present |
| frm_ready | output | 1 | The block accepts a beat (high whenever out of reset) |
| frm_index | input | 4 | Position of the frame in the multiframe, 0 to 15 |
| frm_sa | input | 5 | The frame's Sa bits: bit 0 = Sa4 … bit 4 = Sa8 |
| mf_lock | input | 1 | The receiver holds multiframe lock |
| cfg_sa_sel | input | 3 | Which Sa bit to watch |
| cfg_user_pat | input | 1 | 1 = use the user patterns instead of the built-in ones |
| cfg_pat_a | input | 4 | First user pattern |
| cfg_pat_b | input | 4 | Second user pattern |
| latch | input | 1 | Copy the count to `hold_cnt` and clear the running count |
| hold_cnt | output | 16 | Count captured by the last latch |

## Verification
The assertions check the following on every cycle:
- `frm_ready` stays high once reset is released.
- No word is produced on a cycle after lock was low.
- Words appear only after a beat at index 7 or 15.
- The running count steps by at most one, stays put once it reaches all ones, and moves into the holding register when latched, cleared or reloaded with the coincident increment.

Only the bench scenarios can show which word is built from which Sa bit, in which bit order, and whether it matches the right pattern pair. The same goes for dropping a partial word when lock is lost or a beat is skipped, and for the final values seen through `hold_cnt`.

// File: rtl/sa_err_pkg.sv
package sa_err_pkg;
  localparam int SA_NUM = 5;
  localparam int SEL_W  = $clog2(SA_NUM) + ((SA_NUM & (SA_NUM - 1)) == 0 ? 1 : 0);
  localparam int NUM_PAT = 2;

  typedef enum logic [2:0] {
    SEL_SA4 = 3'd0,
    SEL_SA5 = 3'd1,
    SEL_SA6 = 3'd2,
    SEL_SA7 = 3'd3,
    SEL_SA8 = 3'd4
  } sa_sel_e;
endpackage

// File: rtl/sa_bit_pick.sv
module sa_bit_pick
  import sa_err_pkg::*;
(
  input  logic [SA_NUM-1:0] sa_in,
  input  logic [2:0]        sel,
  output logic              bit_out
);
  logic [2:0] eff_sel;

  always_comb begin
    if (sel > 3'(SA_NUM - 1)) eff_sel = 3'(SEL_SA8);
    else                      eff_sel = sel;
    bit_out = sa_in[eff_sel];
  end
endmodule

// File: rtl/sa_word_collect.sv
module sa_word_collect #(
  parameter int WORD_LEN = 4,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic [IDX_W-1:0]    idx,
  input  logic                bit_in,
  input  logic                lock,
  output logic                word_vld,
  output logic [WORD_LEN-1:0] word
);
  localparam int SMF_FRAMES = 2 * WORD_LEN;
  localparam int POS_W      = $clog2(SMF_FRAMES);
  localparam int HALF_W     = IDX_W - POS_W;
  localparam int NB_W       = $clog2(WORD_LEN) + 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SMF_FRAMES - 1);

  logic [POS_W-1:0]    pos;
  logic [HALF_W-1:0]   half;
  logic [HALF_W-1:0]   half_q;
  logic                armed;
  logic [NB_W-1:0]     nbits;
  logic [WORD_LEN-1:0] shreg;
  logic [WORD_LEN-1:0] next_word;

  assign pos       = idx[POS_W-1:0];
  assign half      = idx[IDX_W-1:POS_W];
  assign next_word = {shreg[WORD_LEN-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      half_q   <= '0;
      nbits    <= '0;
      shreg    <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!lock) begin
        armed <= 1'b0;
        nbits <= '0;
      end else if (beat) begin
        if (pos == '0) begin
          armed  <= 1'b1;
          half_q <= half;
          nbits  <= '0;
        end else if (armed && (half != half_q)) begin
          armed <= 1'b0;
        end else if (armed && pos[0]) begin
          shreg <= next_word;
          nbits <= nbits + 1'b1;
          if (pos == LAST_POS) begin
            armed    <= 1'b0;
            word     <= next_word;
            word_vld <= (nbits == NB_W'(WORD_LEN - 1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/sa_pat_match.sv
module sa_pat_match
  import sa_err_pkg::*;
#(
  parameter int WORD_LEN = 4,
  parameter logic [NUM_PAT-1:0][WORD_LEN-1:0] DEF_PAT = {4'b0011, 4'b0010}
) (
  input  logic                             word_vld,
  input  logic [WORD_LEN-1:0]              word,
  input  logic                             use_user,
  input  logic [NUM_PAT-1:0][WORD_LEN-1:0] user_pat,
  output logic                             hit
);
  logic [NUM_PAT-1:0] eq;

  for (genvar k = 0; k < NUM_PAT; k++) begin : g_cmp
    logic [WORD_LEN-1:0] ref_w;
    assign ref_w = use_user ? user_pat[k] : DEF_PAT[k];
    assign eq[k] = (word == ref_w);
  end

  assign hit = word_vld && (|eq);
endmodule

// File: rtl/sa_err_counter.sv
module sa_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             latch,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      hold <= '0;
    end else if (latch) begin
      hold <= live;
      live <= {{(CNT_W-1){1'b0}}, inc};
    end else if (inc && (live != CNT_MAX)) begin
      live <= live + 1'b1;
    end
  end
endmodule

// File: rtl/sa_err_report_cnt.sv
module sa_err_report_cnt
  import sa_err_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WORD_LEN = 4,
  parameter logic [WORD_LEN-1:0] DEF_PAT_A = 4'b0010,
  parameter logic [WORD_LEN-1:0] DEF_PAT_B = 4'b0011,
  localparam int SMF_FRAMES = 2 * WORD_LEN,
  localparam int MF_FRAMES  = 2 * SMF_FRAMES,
  localparam int IDX_W      = $clog2(MF_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  output logic                frm_ready,
  input  logic [IDX_W-1:0]    frm_index,
  input  logic [SA_NUM-1:0]   frm_sa,
  input  logic                mf_lock,
  input  logic [2:0]          cfg_sa_sel,
  input  logic                cfg_user_pat,
  input  logic [WORD_LEN-1:0] cfg_pat_a,
  input  logic [WORD_LEN-1:0] cfg_pat_b,
  input  logic                latch,
  output logic [CNT_W-1:0]    hold_cnt
);
  logic                beat;
  logic                sel_bit;
  logic                word_vld;
  logic [WORD_LEN-1:0] word;
  logic                hit;
  logic [CNT_W-1:0]    live_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) frm_ready <= 1'b0;
    else        frm_ready <= 1'b1;
  end

  assign beat = frm_valid && frm_ready;

  sa_bit_pick u_pick (
    .sa_in   (frm_sa),
    .sel     (cfg_sa_sel),
    .bit_out (sel_bit)
  );

  sa_word_collect #(.WORD_LEN(WORD_LEN), .IDX_W(IDX_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .idx      (frm_index),
    .bit_in   (sel_bit),
    .lock     (mf_lock),
    .word_vld (word_vld),
    .word     (word)
  );

  sa_pat_match #(
    .WORD_LEN (WORD_LEN),
    .DEF_PAT  ({DEF_PAT_B, DEF_PAT_A})
  ) u_match (
    .word_vld (word_vld),
    .word     (word),
    .use_user (cfg_user_pat),
    .user_pat ({cfg_pat_b, cfg_pat_a}),
    .hit      (hit)
  );

  sa_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (hit),
    .latch (latch),
    .live  (live_cnt),
    .hold  (hold_cnt)
  );
endmodule

// File: rtl/sa_err_report_cnt_chk.sv
module sa_err_report_cnt_chk #(
  parameter int CNT_W    = 16,
  parameter int WORD_LEN = 4,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic [IDX_W-1:0] frm_index,
  input logic             mf_lock,
  input logic             latch,
  input logic             word_vld,
  input logic             hit,
  input logic [CNT_W-1:0] live_cnt,
  input logic [CNT_W-1:0] hold_cnt
);
  localparam int POS_W = $clog2(2 * WORD_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(2 * WORD_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  assert_ready_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> frm_ready);

  assert_no_word_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lock |=> !word_vld);

  assert_word_at_last_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ($past(frm_valid && frm_ready) && ($past(frm_index[POS_W-1:0]) == LAST_POS)));

  assert_step_by_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ((live_cnt == $past(live_cnt)) || (live_cnt == $past(live_cnt) + 1'b1)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && (live_cnt == CNT_MAX)) |=> (live_cnt == CNT_MAX));

  assert_latch_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (hold_cnt == $past(live_cnt)));

  assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (live_cnt == {{(CNT_W-1){1'b0}}, $past(hit)}));
endmodule

bind sa_err_report_cnt sa_err_report_cnt_chk #(
  .CNT_W    (CNT_W),
  .WORD_LEN (WORD_LEN),
  .IDX_W    (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .frm_index (frm_index),
  .mf_lock   (mf_lock),
  .latch     (latch),
  .word_vld  (word_vld),
  .hit       (hit),
  .live_cnt  (live_cnt),
  .hold_cnt  (hold_cnt)
);

// File: tb/tb_sa_err_report_cnt.sv
`timescale 1ns/1ps
module tb_sa_err_report_cnt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic        frm_ready_s;
  logic [3:0]  frm_index = '0;
  logic [4:0]  frm_sa = '0;
  logic        mf_lock = 1'b0;
  logic [2:0]  cfg_sa_sel = '0;
  logic        cfg_user_pat = 1'b0;
  logic [3:0]  cfg_pat_a = '0;
  logic [3:0]  cfg_pat_b = '0;
  logic        latch = 1'b0;
  logic [15:0] hold_cnt;
  logic [2:0]  hold_sat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sa_err_report_cnt dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_index(frm_index), .frm_sa(frm_sa), .mf_lock(mf_lock),
    .cfg_sa_sel(cfg_sa_sel), .cfg_user_pat(cfg_user_pat),
    .cfg_pat_a(cfg_pat_a), .cfg_pat_b(cfg_pat_b), .latch(latch),
    .hold_cnt(hold_cnt)
  );

  sa_err_report_cnt #(.CNT_W(3)) dut_sat (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready_s),
    .frm_index(frm_index), .frm_sa(frm_sa), .mf_lock(mf_lock),
    .cfg_sa_sel(cfg_sa_sel), .cfg_user_pat(cfg_user_pat),
    .cfg_pat_a(cfg_pat_a), .cfg_pat_b(cfg_pat_b), .latch(latch),
    .hold_cnt(hold_sat)
  );

  // {sel[2:0], user, pat_a[3:0], pat_b[3:0], word[3:0], lock, expect}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 1'b0, 4'h0, 4'h0, 4'b0010, 1'b1, 1'b1},  // R5
    {3'd0, 1'b0, 4'h0, 4'h0, 4'b0011, 1'b1, 1'b1},  // R5
    {3'd0, 1'b0, 4'h0, 4'h0, 4'b0001, 1'b1, 1'b0},  // R5
    {3'd2, 1'b0, 4'h0, 4'h0, 4'b0011, 1'b1, 1'b1},  // R3
    {3'd4, 1'b0, 4'h0, 4'h0, 4'b0010, 1'b1, 1'b1},  // R3
    {3'd6, 1'b0, 4'h0, 4'h0, 4'b0010, 1'b1, 1'b1},  // R3 out of range -> Sa8
    {3'd1, 1'b0, 4'h0, 4'h0, 4'b1010, 1'b1, 1'b0},  // R4 order
    {3'd3, 1'b1, 4'hC, 4'h5, 4'b0101, 1'b1, 1'b1},  // R6
    {3'd3, 1'b1, 4'hC, 4'h5, 4'b1100, 1'b1, 1'b1},  // R6
    {3'd3, 1'b1, 4'hC, 4'h5, 4'b0010, 1'b1, 1'b0},  // R6 built-in off
    {3'd0, 1'b0, 4'h0, 4'h0, 4'b0010, 1'b0, 1'b0},  // R7
    {3'd2, 1'b1, 4'hF, 4'h0, 4'b0000, 1'b1, 1'b1}   // R6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [3:0] idx, input logic [4:0] sa,
                            input logic lk, input logic vld);
    @(negedge clk);
    frm_valid = vld;
    frm_index = idx;
    frm_sa    = sa;
    mf_lock   = lk;
    @(posedge clk);
  endtask

  // Sa value for a frame: the watched bit carries the word bit, the others its inverse.
  function automatic logic [4:0] sa_for(input int pos, input logic [3:0] w, input logic [2:0] sel);
    int eff;
    logic b;
    eff = (sel > 3'd4) ? 4 : int'(sel);
    if ((pos % 2) == 0) return 5'b10101;
    b = w[3 - (pos / 2)];
    return b ? (5'b00001 << eff) : ~(5'b00001 << eff);
  endfunction

  task automatic send_smf(input logic [3:0] base, input logic [3:0] w,
                          input logic [2:0] sel, input logic [7:0] lmask);
    for (int f = 0; f < 8; f++)
      send_frame(base + 4'(f), sa_for(f, w, sel), lmask[f], 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_valid = 1'b0;
    end
  endtask

  task automatic do_latch();
    @(negedge clk);
    frm_valid = 1'b0;
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 100000 && !done; wd++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 hold in reset", int'(hold_cnt), 0);
    chk("R1 ready in reset", int'(frm_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 ready after reset", int'(frm_ready), 1);
    mf_lock = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      cfg_sa_sel   = VEC[v][17:15];
      cfg_user_pat = VEC[v][14];
      cfg_pat_a    = VEC[v][13:10];
      cfg_pat_b    = VEC[v][9:6];
      send_smf((v % 2 == 1) ? 4'd8 : 4'd0, VEC[v][5:2], VEC[v][17:15],
               VEC[v][1] ? 8'hFF : 8'h00);
      idle(2);
      do_latch();
      chk($sformatf("R4/R5/R6/R3/R7 vector %0d", v), int'(hold_cnt), int'(VEC[v][0]));
    end
    cfg_sa_sel = 3'd0;
    cfg_user_pat = 1'b0;

    // R7: lock lost at frame 4
    send_smf(4'd0, 4'b0010, 3'd0, 8'b1110_1111);
    idle(2); do_latch();
    chk("R7 lock lost mid submultiframe", int'(hold_cnt), 0);

    // R7: lock low on an idle cycle between frames
    for (int f = 0; f < 4; f++) send_frame(4'(f), sa_for(f, 4'b0011, 3'd0), 1'b1, 1'b1);
    send_frame(4'd4, 5'h00, 1'b0, 1'b0);
    for (int f = 4; f < 8; f++) send_frame(4'(f), sa_for(f, 4'b0011, 3'd0), 1'b1, 1'b1);
    idle(2); do_latch();
    chk("R7 lock low between beats", int'(hold_cnt), 0);

    // R7: collection begun mid submultiframe does not count; next full one does
    for (int f = 4; f < 8; f++) send_frame(4'(8 + f), sa_for(f, 4'b0010, 3'd0), 1'b1, 1'b1);
    send_smf(4'd0, 4'b0010, 3'd0, 8'hFF);
    idle(2); do_latch();
    chk("R7 restart at boundary", int'(hold_cnt), 1);

    // R4: frames must stay in one submultiframe
    for (int f = 0; f < 4; f++) send_frame(4'(f), sa_for(f, 4'b0010, 3'd0), 1'b1, 1'b1);
    for (int f = 4; f < 8; f++) send_frame(4'(8 + f), sa_for(f, 4'b0010, 3'd0), 1'b1, 1'b1);
    idle(2); do_latch();
    chk("R4 mixed halves", int'(hold_cnt), 0);

    // R2: beat with valid low at index 7 is ignored; then a real one counts
    for (int f = 0; f < 7; f++) send_frame(4'(f), sa_for(f, 4'b0010, 3'd0), 1'b1, 1'b1);
    send_frame(4'd7, sa_for(7, 4'b0010, 3'd0), 1'b1, 1'b0);
    idle(2); do_latch();
    chk("R2 valid low ignored", int'(hold_cnt), 0);
    send_frame(4'd7, sa_for(7, 4'b0010, 3'd0), 1'b1, 1'b1);
    idle(2); do_latch();
    chk("R2 valid beat taken", int'(hold_cnt), 1);

    // R8: accumulation, R10: clear
    for (int k = 0; k < 3; k++) send_smf(4'(8 * (k % 2)), 4'b0011, 3'd0, 8'hFF);
    idle(2); do_latch();
    chk("R8 three matches", int'(hold_cnt), 3);
    do_latch();
    chk("R10 cleared after latch", int'(hold_cnt), 0);

    // R10: increment on the latch edge
    send_smf(4'd0, 4'b0010, 3'd0, 8'hFF);
    idle(2);
    send_smf(4'd8, 4'b0010, 3'd0, 8'hFF);
    @(negedge clk);
    frm_valid = 1'b0;
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
    chk("R10 hold on coincident edge", int'(hold_cnt), 1);
    idle(2); do_latch();
    chk("R10 increment kept in cleared count", int'(hold_cnt), 1);

    // R9 on the narrow instance, R11 on the wide one
    for (int k = 0; k < 9; k++) send_smf(4'(8 * (k % 2)), 4'b0010, 3'd0, 8'hFF);
    idle(2); do_latch();
    chk("R9 saturates at all ones", int'(hold_sat), 7);
    chk("R11 wide counter no wrap", int'(hold_cnt), 9);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule